// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Layer

This block is the addressing layer of a single-wire bus slave with a fixed 64-bit identity. It sits between a slot decoder and the function layer of the device. The slot decoder handles line timing. It hands this block three kinds of event: a pulse when a bus reset and presence sequence has finished, a strobe for each bit the master writes, and a request for each read slot. On a read slot the block answers with the bit it wants on the line. A 1 means the line is released and a 0 means it is pulled low, so several slaves on one line combine as a wired AND.

After each bus reset the block takes one 8-bit ROM command and runs it. It can stream out its identity, compare the identity against an address from the master, skip addressing, or take part in the bit-by-bit elimination search. There are two search variants: the normal one, and one in which the block only takes part while an external alarm flag is high. When an addressing sequence ends with the device selected, the block raises a function-enable output. That output stays high until the next bus reset, and it unlocks the layer above.

Top module: `owr_rom_layer`

## Requirements
- R1: After the synchronous reset `rst`, `func_en_o` is 0 and read slots return 1. Command bits are ignored until the first `bus_reset_i` pulse.
- R2: After a `bus_reset_i` pulse, the next 8 write strobes form the command byte, least significant bit first. The codes are 33h (read identity), 55h (match identity), CCh (skip), F0h (search) and ECh (alarm search).
- R3: Read identity returns the 64 identity bits on 64 read slots, least significant bit first. Bits 7:0 are the family code 28h and bits 55:8 are the serial number. Bits 63:56 are the CRC of bits 55:0, computed least significant bit first with polynomial x^8+x^5+x^4+1 and initial value 0. `func_en_o` rises after the 64th slot.
- R4: Match identity takes 64 write strobes. If all of them equal the identity bits in order, `func_en_o` rises after the 64th strobe, and not before.
- R5: In match identity, one differing bit makes the block quiet until the next bus reset. While quiet, `func_en_o` stays 0, every read slot returns 1, and command bits are ignored.
- R6: Search handles each of the 64 positions in turn: a read slot returns the identity bit, a second read slot returns its complement, and then a write strobe gives the master's direction. If every direction matches, `func_en_o` rises after the 64th direction.
- R7: In search, a direction that differs from the block's own bit makes it quiet (as in R5) until the next bus reset.
- R8: Alarm search behaves as search when `alarm_i` is high as the command byte completes. Otherwise the block goes quiet.
- R9: Skip raises `func_en_o` in the cycle after the 8th command bit.
- R10: Any other command byte makes the block quiet with `func_en_o` at 0.
- R11: A `bus_reset_i` pulse aborts any sequence, clears `func_en_o` on the next cycle and restarts command reception. If a strobe arrives in the same cycle as the pulse, the pulse takes priority.
- R12: While `func_en_o` is high it stays high until a bus reset, and read slots return 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | One-cycle pulse: bus reset and presence finished |
| rx_valid_i | input | 1 | One-cycle strobe: master wrote a bit |
| rx_bit_i | input | 1 | Value of the written bit |
| tx_req_i | input | 1 | One-cycle read-slot request |
| tx_bit_o | output | 1 | Bit to place on the line for the current read slot (1 = release) |
| alarm_i | input | 1 | External alarm flag for alarm search |
| func_en_o | output | 1 | Function layer may run |

## Verification
The hardest state to reach from the ports is dropping out of a search at a chosen deep position. To get there, the bench has to read back and confirm every earlier true/complement pair and write the correct direction for each of those positions. The stimulus walks the search with directions computed from the expected identity. It picks a random position with a fixed seed and inverts the direction only there. Every later slot must then read as released, and function enable must stay low. Match failures at random positions, and a bus reset that collides with a write strobe, are driven the same way.

// File: rtl/owr_rom_pkg.sv
package owr_rom_pkg;

    localparam int ID_W  = 64;
    localparam int IDX_W = $clog2(ID_W);
    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] OP_READ   = 8'h33;
    localparam logic [CMD_W-1:0] OP_MATCH  = 8'h55;
    localparam logic [CMD_W-1:0] OP_SKIP   = 8'hCC;
    localparam logic [CMD_W-1:0] OP_SEARCH = 8'hF0;
    localparam logic [CMD_W-1:0] OP_ALARM  = 8'hEC;

    typedef enum logic [2:0] {
        ST_QUIET,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SEARCH,
        ST_FUNC
    } rom_state_e;

    typedef enum logic [1:0] {
        PH_TRUE,
        PH_COMP,
        PH_DIR
    } srch_phase_e;

    typedef struct packed {
        rom_state_e  state;
        srch_phase_e phase;
    } rom_ctl_s;

    // CRC-8 with reflected polynomial x^8+x^5+x^4+1, bits taken LSB first
    function automatic logic [7:0] crc8_lsb(input logic [55:0] data);
        logic [7:0] acc;
        logic       fb;
        acc = 8'h00;
        for (int i = 0; i < 56; i++) begin
            fb  = acc[0] ^ data[i];
            acc = acc >> 1;
            if (fb) acc = acc ^ 8'h8C;
        end
        return acc;
    endfunction

    function automatic logic [ID_W-1:0] build_id(input logic [7:0]  family,
                                                 input logic [47:0] serial);
        logic [55:0] body;
        body = {serial, family};
        return {crc8_lsb(body), body};
    endfunction

endpackage

// File: rtl/owr_lsb_shifter.sv
module owr_lsb_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    // Keeps the earlier W-1 bits; the newest bit completes the word
    logic [W-2:0] held;

    assign word_o = {bit_i, held};

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            held <= '0;
        end else if (shift_i) begin
            held <= word_o[W-1:1];
        end
    end
endmodule

// File: rtl/owr_bit_cursor.sv
module owr_bit_cursor #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         step_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_o <= '0;
        end else if (step_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/owr_id_rom.sv
module owr_id_rom
    import owr_rom_pkg::*;
#(
    parameter logic [7:0]  FAMILY = 8'h28,
    parameter logic [47:0] SERIAL = 48'h0000_1A2B_3C4D
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             bit_o
);
    localparam logic [ID_W-1:0] IDENT = build_id(FAMILY, SERIAL);

    assign bit_o = IDENT[idx_i];
endmodule

// File: rtl/owr_rom_layer.sv
module owr_rom_layer
    import owr_rom_pkg::*;
#(
    parameter logic [7:0]  FAMILY = 8'h28,
    parameter logic [47:0] SERIAL = 48'h0000_1A2B_3C4D
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_reset_i,
    input  logic rx_valid_i,
    input  logic rx_bit_i,
    input  logic tx_req_i,
    output logic tx_bit_o,
    input  logic alarm_i,
    output logic func_en_o
);
    localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_W - 1);
    localparam logic [IDX_W-1:0] ID_LAST  = IDX_W'(ID_W - 1);

    rom_ctl_s ctl_q, ctl_d;

    logic             cur_clr, cur_step;
    logic [IDX_W-1:0] cur;
    logic             sh_clr, sh_en;
    logic [CMD_W-1:0] cmd_word;
    logic             id_bit;

    owr_bit_cursor #(.W(IDX_W)) u_cursor (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (cur_clr),
        .step_i (cur_step),
        .cnt_o  (cur)
    );

    owr_lsb_shifter #(.W(CMD_W)) u_cmd (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (sh_clr),
        .shift_i (sh_en),
        .bit_i   (rx_bit_i),
        .word_o  (cmd_word)
    );

    owr_id_rom #(.FAMILY(FAMILY), .SERIAL(SERIAL)) u_id (
        .idx_i (cur),
        .bit_o (id_bit)
    );

    always_comb begin
        ctl_d    = ctl_q;
        cur_clr  = 1'b0;
        cur_step = 1'b0;
        sh_clr   = 1'b0;
        sh_en    = 1'b0;
        if (bus_reset_i) begin
            ctl_d.state = ST_CMD;
            ctl_d.phase = PH_TRUE;
            cur_clr     = 1'b1;
            sh_clr      = 1'b1;
        end else begin
            unique case (ctl_q.state)
                ST_CMD: begin
                    if (rx_valid_i) begin
                        sh_en    = 1'b1;
                        cur_step = 1'b1;
                        if (cur == CMD_LAST) begin
                            cur_clr     = 1'b1;
                            ctl_d.phase = PH_TRUE;
                            case (cmd_word)
                                OP_READ:   ctl_d.state = ST_READ;
                                OP_MATCH:  ctl_d.state = ST_MATCH;
                                OP_SKIP:   ctl_d.state = ST_FUNC;
                                OP_SEARCH: ctl_d.state = ST_SEARCH;
                                OP_ALARM:  ctl_d.state = alarm_i ? ST_SEARCH : ST_QUIET;
                                default:   ctl_d.state = ST_QUIET;
                            endcase
                        end
                    end
                end
                ST_READ: begin
                    if (tx_req_i) begin
                        cur_step = 1'b1;
                        if (cur == ID_LAST) ctl_d.state = ST_FUNC;
                    end
                end
                ST_MATCH: begin
                    if (rx_valid_i) begin
                        cur_step = 1'b1;
                        if (rx_bit_i != id_bit)  ctl_d.state = ST_QUIET;
                        else if (cur == ID_LAST) ctl_d.state = ST_FUNC;
                    end
                end
                ST_SEARCH: begin
                    unique case (ctl_q.phase)
                        PH_TRUE: if (tx_req_i) ctl_d.phase = PH_COMP;
                        PH_COMP: if (tx_req_i) ctl_d.phase = PH_DIR;
                        default: begin
                            if (rx_valid_i) begin
                                cur_step    = 1'b1;
                                ctl_d.phase = PH_TRUE;
                                if (rx_bit_i != id_bit)  ctl_d.state = ST_QUIET;
                                else if (cur == ID_LAST) ctl_d.state = ST_FUNC;
                            end
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.state <= ST_QUIET;
            ctl_q.phase <= PH_TRUE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        tx_bit_o = 1'b1;
        if (ctl_q.state == ST_READ) begin
            tx_bit_o = id_bit;
        end else if (ctl_q.state == ST_SEARCH) begin
            if (ctl_q.phase == PH_TRUE)      tx_bit_o = id_bit;
            else if (ctl_q.phase == PH_COMP) tx_bit_o = ~id_bit;
        end
    end

    assign func_en_o = (ctl_q.state == ST_FUNC);
endmodule

// File: rtl/owr_rom_layer_chk.sv
module owr_rom_layer_chk (
    input logic clk,
    input logic rst,
    input logic bus_reset_i,
    input logic rx_valid_i,
    input logic tx_req_i,
    input logic tx_bit_o,
    input logic func_en_o
);
    // R1: leaving reset the function layer is locked
    assert_reset_locked_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !func_en_o);

    // R11: a bus reset pulse clears enable on the next cycle
    assert_bus_reset_clears_R11: assert property (@(posedge clk) disable iff (rst)
        bus_reset_i |=> !func_en_o);

    // R12: enable holds until a bus reset
    assert_enable_holds_R12: assert property (@(posedge clk) disable iff (rst)
        (func_en_o && !bus_reset_i) |=> func_en_o);

    // R12: once enabled, the line is released
    assert_enable_releases_R12: assert property (@(posedge clk) disable iff (rst)
        func_en_o |-> tx_bit_o);

    // R9: enable only rises after a slot event
    assert_enable_from_slot_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(func_en_o) |-> $past(rx_valid_i || tx_req_i));
endmodule

bind owr_rom_layer owr_rom_layer_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_reset_i (bus_reset_i),
    .rx_valid_i  (rx_valid_i),
    .tx_req_i    (tx_req_i),
    .tx_bit_o    (tx_bit_o),
    .func_en_o   (func_en_o)
);

// File: tb/test_owr_rom_layer.sv
module test_owr_rom_layer;
    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] SER = 48'hB35A_0C91_7E24;
    localparam int WATCHDOG = 150000;

    logic clk = 0, rst = 1;
    logic bus_reset = 0, rx_valid = 0, rx_bit = 0, tx_req = 0, alarm = 0;
    logic tx_bit, func_en;
    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    owr_rom_layer #(.FAMILY(8'h28), .SERIAL(SER)) i_owr_rom_layer (
        .clk(clk), .rst(rst), .bus_reset_i(bus_reset), .rx_valid_i(rx_valid),
        .rx_bit_i(rx_bit), .tx_req_i(tx_req), .tx_bit_o(tx_bit),
        .alarm_i(alarm), .func_en_o(func_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] tb_crc(input logic [63:0] d, input int n);
        logic [7:0] c = 0;
        for (int i = 0; i < n; i++) begin
            logic f = c[0] ^ d[i];
            c = c >> 1;
            if (f) c ^= 8'h8C;
        end
        return c;
    endfunction

    function automatic logic [63:0] exp_id();
        logic [63:0] v;
        v[55:0]  = {SER, 8'h28};
        v[63:56] = tb_crc({8'h00, v[55:0]}, 56);
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_rst();
        bus_reset = 1; @(negedge clk); bus_reset = 0;
    endtask
    task automatic wbit(input logic b);
        rx_valid = 1; rx_bit = b; @(negedge clk); rx_valid = 0;
    endtask
    task automatic rbit(output logic b);
        tx_req = 1; #1 b = tx_bit; @(negedge clk); tx_req = 0;
    endtask
    // command bytes go out LSB first (R2)
    task automatic wbyte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wbit(v[i]);
    endtask
    task automatic rd64(output logic [63:0] v);
        for (int i = 0; i < 64; i++) rbit(v[i]);
    endtask
    task automatic expect_quiet(input string req);
        logic [63:0] v;
        rd64(v);
        check(v == '1, req, v, '1);
        wbyte(8'hCC);
        check(func_en == 0, req, func_en, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] id, v;
        logic b, t, c;
        int k;
        void'($urandom(32'h1D5E_ED01));
        id = exp_id();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state, command ignored before first bus reset
        check(func_en == 0, "R1 reset enable", func_en, 0);
        rbit(b);
        check(b == 1, "R1 reset released", b, 1);
        wbyte(8'hCC);
        check(func_en == 0, "R1 no bus reset", func_en, 0);

        // R2 R9: skip enables right after the 8th bit
        bus_rst();
        for (int i = 0; i < 7; i++) wbit(i[0] ? 1'b0 : 1'b0);
        bus_rst();
        wbyte(8'hCC);
        check(func_en == 1, "R9 R2 skip", func_en, 1);
        // R11: bus reset clears enable
        bus_rst();
        check(func_en == 0, "R11 clear", func_en, 0);

        // R3: read identity
        wbyte(8'h33);
        for (int i = 0; i < 63; i++) rbit(v[i]);
        check(func_en == 0, "R3 early enable", func_en, 0);
        rbit(v[63]);
        check(v == id, "R3 identity", v, id);
        check(tb_crc(v, 64) == 0, "R3 crc residue", tb_crc(v, 64), 0);
        check(func_en == 1, "R3 enable", func_en, 1);
        // R12: enable holds and line released
        wbyte(8'h55);
        rbit(b);
        check(func_en == 1 && b == 1, "R12 hold", {func_en, b}, 2'b11);

        // R4: full match
        bus_rst(); wbyte(8'h55);
        for (int i = 0; i < 63; i++) wbit(id[i]);
        check(func_en == 0, "R4 early enable", func_en, 0);
        wbit(id[63]);
        check(func_en == 1, "R4 match", func_en, 1);

        // R5: mismatch at random positions
        for (int n = 0; n < 6; n++) begin
            k = (n == 0) ? 63 : int'($urandom % 64);
            bus_rst(); wbyte(8'h55);
            for (int i = 0; i < 64; i++) wbit(i == k ? ~id[i] : id[i]);
            check(func_en == 0, "R5 mismatch", k, 0);
            expect_quiet("R5 quiet");
        end

        // R6: full search
        bus_rst(); wbyte(8'hF0);
        begin
            int bad = 0;
            for (int i = 0; i < 64; i++) begin
                rbit(t); rbit(c);
                if (t != id[i] || c != ~id[i]) bad++;
                wbit(id[i]);
            end
            check(bad == 0, "R6 search pairs", bad, 0);
        end
        check(func_en == 1, "R6 search enable", func_en, 1);

        // R7: wrong direction drops out
        for (int n = 0; n < 6; n++) begin
            k = (n == 0) ? 0 : int'($urandom % 64);
            bus_rst(); wbyte(8'hF0);
            for (int i = 0; i <= k; i++) begin
                rbit(t); rbit(c);
                wbit(i == k ? ~id[i] : id[i]);
            end
            check(func_en == 0, "R7 drop enable", k, 0);
            expect_quiet("R7 quiet");
        end

        // R8: alarm search with and without alarm
        alarm = 1;
        bus_rst(); wbyte(8'hEC);
        alarm = 0;
        rbit(t); rbit(c);
        check(t == id[0] && c == ~id[0], "R8 alarm pair", {t, c}, {id[0], ~id[0]});
        wbit(id[0]);
        for (int i = 1; i < 64; i++) begin rbit(t); rbit(c); wbit(id[i]); end
        check(func_en == 1, "R8 alarm enable", func_en, 1);
        bus_rst(); wbyte(8'hEC);
        check(func_en == 0, "R8 no alarm", func_en, 0);
        expect_quiet("R8 quiet");

        // R10: unknown commands
        for (int n = 0; n < 8; n++) begin
            logic [7:0] op;
            do op = 8'($urandom); while (op == 8'h33 || op == 8'h55 || op == 8'hCC ||
                                         op == 8'hF0 || op == 8'hEC);
            bus_rst(); wbyte(op);
            check(func_en == 0, "R10 unknown", op, 0);
            expect_quiet("R10 quiet");
        end

        // R11: abort mid read, then collision of pulse and strobe
        bus_rst(); wbyte(8'h33);
        for (int i = 0; i < 10; i++) rbit(b);
        bus_rst(); wbyte(8'hCC);
        check(func_en == 1, "R11 abort read", func_en, 1);
        bus_rst();
        for (int i = 0; i < 7; i++) wbit(i < 2 ? 1'b0 : 1'b1);
        bus_reset = 1; rx_valid = 1; rx_bit = 1; @(negedge clk);
        bus_reset = 0; rx_valid = 0;
        check(func_en == 0, "R11 collision", func_en, 0);
        wbyte(8'hCC);
        check(func_en == 1, "R11 restart", func_en, 1);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule